// File: doc/BRIEF.md
# External Edge Interrupt Unit

This block sits between eight external input pins and the chip's interrupt controller. Lines 1 to 7 can each raise an interrupt request. Line 0 exists in the registers, but it never raises a request. Each line passes through a two-stage synchronizer. A per-line trigger mode then treats the synchronized value in one of two ways:

- **Level mode:** an active-low level that reaches the request directly.
- **Edge modes:** a source of edge events. An event latches into a per-line flag, and software clears that flag by writing a one to it.

A line's request is its enable bit ANDed with either its active level or its latched flag.

Software reaches the unit through a simple single-cycle register port. The same port sets the trigger modes, the enables, the pin direction and the value driven on lines set as outputs. Software uses it to read the synchronized pin levels and to clear flags. The trigger mode is decoded in each line's detector by a `unique case` over four named modes:

| Mode | Code | Effect |
|---|---|---|
| `TRIG_LEVEL` | 00 | Request follows the low pin level |
| `TRIG_RISE` | 01 | Low-to-high transition latches the flag |
| `TRIG_FALL` | 10 | High-to-low transition latches the flag |
| `TRIG_BOTH` | 11 | Either transition latches the flag |

The flag of each line has two states, clear and latched:

- It moves from clear to latched on an event.
- It moves from latched to clear on a one written to its flag bit, unless an event lands in that same cycle.

Top module: `eport_unit`

## Requirements
- R1: After reset every register reads 0, `pin_oe` and `pin_out` are 0 and `irq_req` is 0. Every line therefore starts as a disabled level-mode input.
- R2: The register address map, with 8-bit registers zero-extended on read, is:
  - 0: trigger modes, 16 bits. Line n uses bits 2n+1:2n.
  - 1: direction. A 1 drives the pin, so `pin_oe` equals this register.
  - 2: output data, which appears on `pin_out`.
  - 3: interrupt enable.
  - 4: event flags.
  - 5: synchronized pin levels, read-only.
- R3: In mode 00 (level) a line requests while its synchronized pin is low and its enable bit is 1. The request appears on the second rising clock edge after the pin falls, and is removed on the second edge after the pin rises.
- R4: Mode 01 latches the flag on a low-to-high transition, mode 10 on high-to-low, and mode 11 on either. The flag and request appear on the third rising edge after the pin changes and stay set while the pin is steady.
- R5: Writing address 4 clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged.
- R6: When an edge event and a clearing write hit the same flag in the same cycle, the flag stays set.
- R7: An enable bit of 0 keeps that line's request low, but the flag still latches. Setting the enable later raises the request from the held flag.
- R8: Line 0 never raises a request and its flag always reads 0, whatever its mode, enable and pin.
- R9: In level mode no edge sets the flag, and writing 1 to that line's flag bit does not change its request.
- R10: An edge opposite to the selected one (a fall in mode 01, a rise in mode 10) leaves the flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| pin_in | input | 8 | External pin levels, asynchronous |
| pin_out | output | 8 | Values driven on pins set as outputs |
| pin_oe | output | 8 | Output enable per pin, 1 drives |
| irq_req | output | 8 | Interrupt request per line to the interrupt controller, bit 0 always 0 |

## Verification
The bench counts clock edges from the pin change to the request. A synchronizer that is one stage short or long shifts the level and edge latencies by a cycle and is caught.

It aims a clearing write at the exact cycle in which a new edge sets the same flag. A design that gives the clear priority would lose that interrupt.

It drives opposite-direction edges and edges on level-mode lines. A detector that decodes the mode bits wrongly would latch spurious flags.

It also probes line 0 with edge mode and enable set, and writes zero bits to the flag register. A design that does not reserve line 0 shows a request there, and one that clears on written zeros loses flags.

// File: rtl/eport_pkg.sv
package eport_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'b00,
        TRIG_RISE  = 2'b01,
        TRIG_FALL  = 2'b10,
        TRIG_BOTH  = 2'b11
    } trig_e;

    typedef enum logic [ADDR_W-1:0] {
        A_MODE = 3'd0,
        A_DIR  = 3'd1,
        A_DATA = 3'd2,
        A_EN   = 3'd3,
        A_FLAG = 3'd4,
        A_PIN  = 3'd5
    } reg_addr_e;

endpackage

// File: rtl/eport_sync.sv
module eport_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/eport_line.sv
module eport_line
    import eport_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pin_s,
    input  trig_e mode,
    output logic  evt,
    output logic  lvl_act
);

    logic prev_q;
    logic rise;
    logic fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_s;
    end

    assign rise = pin_s & ~prev_q;
    assign fall = ~pin_s & prev_q;

    always_comb begin
        evt     = 1'b0;
        lvl_act = 1'b0;
        unique case (mode)
            TRIG_LEVEL: lvl_act = ~pin_s;
            TRIG_RISE:  evt     = rise;
            TRIG_FALL:  evt     = fall;
            TRIG_BOTH:  evt     = rise | fall;
        endcase
    end

endmodule

// File: rtl/eport_regs.sv
module eport_regs
    import eport_pkg::*;
#(
    parameter int LINES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [2*LINES-1:0]  reg_wdata,
    output logic [2*LINES-1:0]  reg_rdata,
    input  logic [LINES-1:0]    set_vec,
    input  logic [LINES-1:0]    pin_sync,
    output logic [2*LINES-1:0]  mode_q,
    output logic [LINES-1:0]    dir_q,
    output logic [LINES-1:0]    data_q,
    output logic [LINES-1:0]    en_q,
    output logic [LINES-1:0]    flag_q
);

    localparam int MODE_W = 2 * LINES;
    localparam int PAD_W  = MODE_W - LINES;

    reg_addr_e          addr_e;
    logic [LINES-1:0]   clr_vec;
    logic [LINES-1:0]   flag_nxt;

    assign addr_e  = reg_addr_e'(reg_addr);
    assign clr_vec = (reg_wr && addr_e == A_FLAG) ? reg_wdata[LINES-1:0] : '0;

    always_comb begin
        flag_nxt    = (flag_q & ~clr_vec) | set_vec;
        flag_nxt[0] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            dir_q  <= '0;
            data_q <= '0;
            en_q   <= '0;
            flag_q <= '0;
        end else begin
            flag_q <= flag_nxt;
            if (reg_wr) begin
                case (addr_e)
                    A_MODE:  mode_q <= reg_wdata;
                    A_DIR:   dir_q  <= reg_wdata[LINES-1:0];
                    A_DATA:  data_q <= reg_wdata[LINES-1:0];
                    A_EN:    en_q   <= reg_wdata[LINES-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (addr_e)
            A_MODE:  reg_rdata = mode_q;
            A_DIR:   reg_rdata = {{PAD_W{1'b0}}, dir_q};
            A_DATA:  reg_rdata = {{PAD_W{1'b0}}, data_q};
            A_EN:    reg_rdata = {{PAD_W{1'b0}}, en_q};
            A_FLAG:  reg_rdata = {{PAD_W{1'b0}}, flag_q};
            A_PIN:   reg_rdata = {{PAD_W{1'b0}}, pin_sync};
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/eport_unit.sv
module eport_unit
    import eport_pkg::*;
#(
    parameter int LINES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [2*LINES-1:0]  reg_wdata,
    output logic [2*LINES-1:0]  reg_rdata,
    input  logic [LINES-1:0]    pin_in,
    output logic [LINES-1:0]    pin_out,
    output logic [LINES-1:0]    pin_oe,
    output logic [LINES-1:0]    irq_req
);

    logic [LINES-1:0]   pin_sync;
    logic [LINES-1:0]   set_vec;
    logic [LINES-1:0]   lvl_vec;
    logic [2*LINES-1:0] mode_q;
    logic [LINES-1:0]   dir_q;
    logic [LINES-1:0]   data_q;
    logic [LINES-1:0]   en_q;
    logic [LINES-1:0]   flag_q;

    eport_sync #(.WIDTH(LINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    eport_regs #(.LINES(LINES)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .set_vec   (set_vec),
        .pin_sync  (pin_sync),
        .mode_q    (mode_q),
        .dir_q     (dir_q),
        .data_q    (data_q),
        .en_q      (en_q),
        .flag_q    (flag_q)
    );

    // Line 0 is reserved: no detector, no event, no level request.
    assign set_vec[0] = 1'b0;
    assign lvl_vec[0] = 1'b0;

    for (genvar i = 1; i < LINES; i++) begin : g_line
        eport_line u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_s   (pin_sync[i]),
            .mode    (trig_e'(mode_q[2*i +: 2])),
            .evt     (set_vec[i]),
            .lvl_act (lvl_vec[i])
        );
    end

    assign irq_req = en_q & (lvl_vec | flag_q);
    assign pin_oe  = dir_q;
    assign pin_out = data_q;

endmodule

// File: rtl/eport_unit_chk.sv
module eport_unit_chk
    import eport_pkg::*;
#(
    parameter int LINES = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [2*LINES-1:0]  reg_wdata,
    input logic [2*LINES-1:0]  mode_q,
    input logic [LINES-1:0]    set_vec,
    input logic [LINES-1:0]    en_q,
    input logic [LINES-1:0]    flag_q,
    input logic [LINES-1:0]    irq_req
);

    logic [LINES-1:0] lvl_mask;
    logic [LINES-1:0] w1c;
    logic             flag_wr;

    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            lvl_mask[i] = (mode_q[2*i +: 2] == 2'b00);
        end
    end

    assign flag_wr = reg_wr && (reg_addr == A_FLAG);
    assign w1c     = flag_wr ? reg_wdata[LINES-1:0] : '0;

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req & ~en_q) == '0); // R7

    AST_LEVEL_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec & lvl_mask) == '0); // R9

    AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((flag_q & $past(set_vec)) == $past(set_vec))); // R6

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && ((w1c & set_vec) == '0)) |=> ((flag_q & $past(w1c)) == '0)); // R5

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_wr && set_vec == '0) |=> $stable(flag_q)); // R5

endmodule

bind eport_unit eport_unit_chk #(.LINES(LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .mode_q    (mode_q),
    .set_vec   (set_vec),
    .en_q      (en_q),
    .flag_q    (flag_q),
    .irq_req   (irq_req)
);

// File: tb/eport_unit_tb.sv
module eport_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SEL_IRQ = 0, SEL_RD = 1, SEL_OE = 2, SEL_OUT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  pins = 8'hFF;
    logic [7:0]  pin_out, pin_oe, irq_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int          sel;
        logic [15:0] exp;
        logic [15:0] mask;
        string       tag;
    } item_t;

    item_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    eport_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_in    (pins),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq_req   (irq_req)
    );

    // Monitor: samples a quarter period after each rising edge.
    initial begin
        forever begin
            item_t       it;
            logic [15:0] act;
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (q.size() > 0) begin
                it = q.pop_front();
                case (it.sel)
                    SEL_IRQ: act = {8'h00, irq_req};
                    SEL_RD:  act = reg_rdata;
                    SEL_OE:  act = {8'h00, pin_oe};
                    default: act = {8'h00, pin_out};
                endcase
                checks++;
                if ((act & it.mask) !== (it.exp & it.mask)) begin
                    errors++;
                    $display("FAIL %s actual %h expected %h (mask %h)",
                             it.tag, act & it.mask, it.exp & it.mask, it.mask);
                end
            end
        end
    end

    // Driver tasks: all start and end at a falling edge.
    task automatic expect_val(input int sel, input logic [15:0] exp,
                              input logic [15:0] mask, input string tag);
        item_t it;
        it.sel = sel; it.exp = exp; it.mask = mask; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] exp,
                      input logic [15:0] mask, input string tag);
        reg_addr = a;
        expect_val(SEL_RD, exp, mask, tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        expect_val(SEL_IRQ, 16'h0, 16'hFF, "R1 irq after reset");
        expect_val(SEL_OE,  16'h0, 16'hFF, "R1 pin_oe after reset");
        expect_val(SEL_OUT, 16'h0, 16'hFF, "R1 pin_out after reset");
        for (int a = 0; a < 5; a++) rd(3'(a), 16'h0, 16'hFFFF, "R1 register after reset");

        // R2 register map
        idle(3);
        rd(3'd5, 16'h00FF, 16'hFFFF, "R2 pin level read");
        wr(3'd1, 16'h000F);
        expect_val(SEL_OE, 16'h0F, 16'hFF, "R2 direction drives pin_oe");
        wr(3'd2, 16'h00A5);
        expect_val(SEL_OUT, 16'hA5, 16'hFF, "R2 data drives pin_out");
        wr(3'd0, 16'h1234);
        rd(3'd0, 16'h1234, 16'hFFFF, "R2 mode readback");
        wr(3'd1, 16'h0000);
        wr(3'd0, 16'h0000);

        // R3 level mode latency on line 1
        wr(3'd3, 16'h0002);
        expect_val(SEL_IRQ, 16'h0, 16'h02, "R3 level idle high");
        pins[1] = 1'b0;
        expect_val(SEL_IRQ, 16'h00, 16'h02, "R3 level one edge after fall");
        expect_val(SEL_IRQ, 16'h02, 16'h02, "R3 level two edges after fall");
        // R9 clear write in level mode
        wr(3'd4, 16'h0002);
        expect_val(SEL_IRQ, 16'h02, 16'h02, "R9 level request survives clear");
        rd(3'd4, 16'h0, 16'h02, "R9 level flag stays clear");
        pins[1] = 1'b1;
        expect_val(SEL_IRQ, 16'h02, 16'h02, "R3 level one edge after rise");
        expect_val(SEL_IRQ, 16'h00, 16'h02, "R3 level two edges after rise");

        // R4 rising on line 2, falling on 3, both on 4
        wr(3'd0, 16'h0390);
        wr(3'd3, 16'h001C);
        pins[2] = 1'b0;
        idle(4);
        rd(3'd4, 16'h0, 16'h04, "R10 fall ignored in rising mode");
        pins[2] = 1'b1;
        expect_val(SEL_IRQ, 16'h00, 16'h04, "R4 rise latency edge 1");
        expect_val(SEL_IRQ, 16'h00, 16'h04, "R4 rise latency edge 2");
        expect_val(SEL_IRQ, 16'h04, 16'h04, "R4 rise latency edge 3");
        idle(3);
        expect_val(SEL_IRQ, 16'h04, 16'h04, "R4 rise flag held");

        // R5 write-one-to-clear
        wr(3'd4, 16'h0000);
        rd(3'd4, 16'h04, 16'h04, "R5 zero write keeps flag");
        wr(3'd4, 16'h0004);
        rd(3'd4, 16'h00, 16'h04, "R5 one write clears flag");
        expect_val(SEL_IRQ, 16'h00, 16'h04, "R5 request drops after clear");

        pins[3] = 1'b0;
        idle(4);
        rd(3'd4, 16'h08, 16'h08, "R4 falling mode latches");
        wr(3'd4, 16'h0008);
        pins[3] = 1'b1;
        idle(4);
        rd(3'd4, 16'h00, 16'h08, "R10 rise ignored in falling mode");

        pins[4] = 1'b0;
        idle(4);
        rd(3'd4, 16'h10, 16'h10, "R4 both mode latches fall");
        wr(3'd4, 16'h0010);
        rd(3'd4, 16'h00, 16'h10, "R5 both mode flag cleared");
        pins[4] = 1'b1;
        idle(4);
        rd(3'd4, 16'h10, 16'h10, "R4 both mode latches rise");
        expect_val(SEL_IRQ, 16'h10, 16'h10, "R4 both mode request");

        // R6 event and clear in the same cycle
        pins[4] = 1'b0;
        idle(2);
        reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 16'h0010;
        @(negedge clk);
        reg_wr = 1'b0;
        rd(3'd4, 16'h10, 16'h10, "R6 event wins over clear");

        // R7 enable gating on line 5
        wr(3'd0, 16'h0790);
        pins[5] = 1'b0;
        idle(4);
        pins[5] = 1'b1;
        idle(4);
        rd(3'd4, 16'h20, 16'h20, "R7 flag latches while disabled");
        expect_val(SEL_IRQ, 16'h00, 16'h20, "R7 no request while disabled");
        wr(3'd3, 16'h003C);
        expect_val(SEL_IRQ, 16'h20, 16'h20, "R7 request after enable");

        // R8 line 0 reserved
        wr(3'd0, 16'h0791);
        wr(3'd3, 16'h003D);
        pins[0] = 1'b0;
        idle(4);
        pins[0] = 1'b1;
        idle(4);
        expect_val(SEL_IRQ, 16'h00, 16'h01, "R8 line 0 no request edge mode");
        rd(3'd4, 16'h00, 16'h01, "R8 line 0 flag clear");
        wr(3'd0, 16'h0790);
        pins[0] = 1'b0;
        idle(4);
        expect_val(SEL_IRQ, 16'h00, 16'h01, "R8 line 0 no request level mode");

        idle(2);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule